// File: doc/BRIEF.md
# Per-Channel Underflow Interrupt Controller

This block gathers per-channel events from a three-output display compositor and turns them into one interrupt line. Each output channel reports three kinds of event as single-cycle pulses: its pixel FIFO ran dry (underflow), it finished a frame, or it finished a line. Every pulse sets a sticky flag that stays set until software clears it, whether or not the interrupt for it is enabled. Enabled pending flags are ORed into a registered interrupt output.

Software uses a small register bus with separate write and read strobes. A control register holds the global enable for the compositor core and one interrupt enable per channel and event kind. A status register shows the raw sticky flags and is cleared by writing 1 to a bit. A separate read-only view shows only the flags whose enable is set. The intended flow before turning an interrupt on is to clear its stale flag first, so that the line does not assert at once. There is no data stream here: all pins are plain control and status signals with no back-pressure.

Top module: `uflow_irq_ctrl`

## Requirements
- R1: After reset, every flag, every enable, `core_en_o` and `irq_o` are 0, and reads of the control, status and pending-view registers return 0.
- R2: A pulse on `uflow_i[c]`, `eof_i[c]` or `eol_i[c]` sets status bit c, 3+c or 6+c on the following clock edge. The flag then stays 1 until a clearing write.
- R3: A write to address 1 clears every status bit written as 1 on that edge and leaves bits written as 0 unchanged. Writing 0x1FF clears all nine flags in one write.
- R4: If an event pulse and a clearing write hit the same flag on the same edge, the flag ends up 1.
- R5: A flag is recorded even while its enable is 0, and such a flag never asserts `irq_o`.
- R6: `irq_o` is a register holding the OR over all status bits s of (flag s AND control bit s+1). It changes one edge after a flag or an enable changes.
- R7: Address 0 is the control register. Bit 0 is the global enable, bits 1..3 the underflow enables for channels 0..2, bits 4..6 the end-of-frame enables, and bits 7..9 the end-of-line enables. Higher bits are ignored on write and read as 0.
- R8: `core_en_o` follows control bit 0.
- R9: Address 2 reads the status flags ANDed with their enables, in the status bit layout. Writes to address 2 change nothing.
- R10: Clearing a stale flag and then setting its enable leaves `irq_o` low.
- R11: `rdata_o` loads the addressed value on the edge where `rd_en_i` is 1 and holds its value while `rd_en_i` is 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uflow_i | input | NUM_CH | Per-channel FIFO underflow pulse |
| eof_i | input | NUM_CH | Per-channel end-of-frame pulse |
| eol_i | input | NUM_CH | Per-channel end-of-line pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Registered interrupt line |
| core_en_o | output | 1 | Global enable to the compositor core |

## Verification
The stimulus first raises an underflow with every enable off. This separates recording a flag from signalling it, because the raw status must show the bit while the pending view and the interrupt stay at zero. Mixed events across all three kinds and several channels, followed by partial clearing writes, show that each status bit is cleared only by its own written 1. A pulse that lands on the same edge as its clearing write shows which of set and clear wins. Turning on an enable over an existing flag, and over a flag that was just cleared, checks that the interrupt comes one edge after the enable and only when something is pending.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int EV_KINDS = 3;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_PEND = 2'd2;
  typedef enum logic [1:0] {
    EV_UFLOW = 2'd0,
    EV_EOF   = 2'd1,
    EV_EOL   = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q[i]); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      flag_q[i] && !clr_i[i] |=> flag_q[i]); // R2
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
      clr_i[i] && !set_i[i] |=> !flag_q[i]); // R3
    AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !flag_q[i] && !set_i[i] |=> !flag_q[i]); // R2
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int FLAG_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [FLAG_W-1:0] en_o,
  output logic              core_en_o,
  output logic [FLAG_W-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CTRL_W = FLAG_W + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_nxt;
  logic              hit_ctrl;
  logic              hit_stat;

  assign hit_ctrl = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign hit_stat = wr_en_i && (addr_i == ADDR_W'(ADDR_STAT));

  always_ff @(posedge clk) begin
    if (rst)           ctrl_q <= '0;
    else if (hit_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign clr_o     = hit_stat ? wdata_i[FLAG_W-1:0] : '0;
  assign en_o      = ctrl_q[CTRL_W-1:1];
  assign core_en_o = ctrl_q[0];

  always_comb begin
    rd_nxt = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL))      rd_nxt[CTRL_W-1:0] = ctrl_q;
    else if (addr_i == ADDR_W'(ADDR_STAT)) rd_nxt[FLAG_W-1:0] = flag_i;
    else if (addr_i == ADDR_W'(ADDR_PEND)) rd_nxt[FLAG_W-1:0] = flag_i & en_o;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_nxt;
  end

  assign rdata_o = rdata_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit_ctrl |=> $stable(ctrl_q)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/uirq_irq_gen.sv
module uirq_irq_gen #(
  parameter int FLAG_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flag_i,
  input  logic [FLAG_W-1:0] en_i,
  output logic              irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_i & en_i);
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(flag_i & en_i)) |=> irq_q); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_i & en_i)) |=> !irq_q); // R5
endmodule

// File: rtl/uflow_irq_ctrl.sv
module uflow_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] uflow_i,
  input  logic [NUM_CH-1:0] eof_i,
  input  logic [NUM_CH-1:0] eol_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              core_en_o
);
  localparam int FLAG_W = EV_KINDS * NUM_CH;

  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] clr_v;
  logic [FLAG_W-1:0] flag_v;
  logic [FLAG_W-1:0] en_v;

  assign set_v = {eol_i, eof_i, uflow_i};

  uirq_flag_bank #(.W(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .flag_o(flag_v)
  );

  uirq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .flag_i(flag_v), .en_o(en_v),
    .core_en_o(core_en_o), .clr_o(clr_v), .rdata_o(rdata_o)
  );

  uirq_irq_gen #(.FLAG_W(FLAG_W)) u_irq (
    .clk(clk), .rst(rst), .flag_i(flag_v), .en_i(en_v), .irq_o(irq_o)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|flag_v)); // R5
endmodule

// File: tb/uflow_irq_ctrl_test.sv
module uflow_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  uflow = '0, eof = '0, eol = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, core_en;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic rv_q = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uflow_irq_ctrl #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst(rst), .uflow_i(uflow), .eof_i(eof), .eol_i(eol),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .core_en_o(core_en)
  );

  always @(posedge clk) rv_q <= rd_en;

  // monitor: pops expected read data the cycle after each read strobe
  always @(negedge clk) begin
    if (rv_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL timeout actual=running expected=done");
      finish_up();
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] u, input logic [2:0] f, input logic [2:0] l);
    @(negedge clk);
    uflow = u; eof = f; eol = l;
    @(negedge clk);
    uflow = '0; eof = '0; eol = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    chk(core_en, 1'b0, "R1 core_en");
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 status");
    rd(2'd2, 32'h0, "R1 pending");

    // R7 control layout, upper bits dropped; R8 core enable
    wr(2'd0, 32'hFFFF_FFFF);
    chk(core_en, 1'b1, "R8 core_en on");
    rd(2'd0, 32'h0000_03FF, "R7 ctrl readback");
    wr(2'd0, 32'h0);
    chk(core_en, 1'b0, "R8 core_en off");

    // R5 masked event recorded, no irq
    pulse(3'b010, 3'b000, 3'b000);
    @(negedge clk);
    chk(irq, 1'b0, "R5 masked irq");
    rd(2'd1, 32'h002, "R2 status after uflow ch1");
    rd(2'd2, 32'h000, "R9 pending view masked");

    // R10 clear stale flag, then enable ch1 underflow (ctrl bit 2)
    wr(2'd1, 32'h002);
    rd(2'd1, 32'h000, "R3 stale cleared");
    wr(2'd0, 32'h004);
    @(negedge clk);
    chk(irq, 1'b0, "R10 irq stays low");

    // R6 irq one edge after flag
    pulse(3'b010, 3'b000, 3'b000);
    chk(irq, 1'b0, "R6 irq not yet");
    @(negedge clk);
    chk(irq, 1'b1, "R6 irq asserted");
    rd(2'd2, 32'h002, "R9 pending view enabled");

    // R2/R3 mixed kinds, partial clear
    pulse(3'b000, 3'b001, 3'b100);
    rd(2'd1, 32'h10A, "R2 mixed flags");
    wr(2'd1, 32'h008);
    rd(2'd1, 32'h102, "R3 partial clear");

    // R9 write to pending view ignored
    wr(2'd2, 32'h1FF);
    rd(2'd1, 32'h102, "R9 write ignored");

    // R4 set wins over simultaneous clear
    @(negedge clk);
    uflow = 3'b010; wr_en = 1'b1; addr = 2'd1; wdata = 32'h002;
    @(negedge clk);
    uflow = '0; wr_en = 1'b0;
    rd(2'd1, 32'h102, "R4 set wins");

    // R3 clear all in one write; R6 irq drops one edge later
    wr(2'd1, 32'h1FF);
    chk(irq, 1'b1, "R6 irq still registered");
    @(negedge clk);
    chk(irq, 1'b0, "R6 irq dropped");
    rd(2'd1, 32'h000, "R3 clear all");

    // R6 enabling over an existing flag
    pulse(3'b000, 3'b000, 3'b001);
    @(negedge clk);
    chk(irq, 1'b0, "R5 eol masked");
    wr(2'd0, 32'h084);
    chk(irq, 1'b0, "R6 irq before enable edge");
    @(negedge clk);
    chk(irq, 1'b1, "R6 irq after enable");
    rd(2'd2, 32'h040, "R9 pending eol ch0");

    // R11 read hold and unmapped address
    rd(2'd0, 32'h084, "R11 ctrl read");
    repeat (2) @(negedge clk);
    total++;
    if (rdata !== 32'h084) begin
      bad++;
      $display("FAIL R11 hold actual=%h expected=%h", rdata, 32'h084);
    end
    rd(2'd3, 32'h0, "R11 unmapped");
    @(negedge clk);
    finish_up();
  end
endmodule